// File: doc/BRIEF.md
# Zero-Turnaround Burst Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM whose word-wide data path carries reads and writes in any mix on every clock, with no idle cycle between them. The rising clock edge registers every address and control input. A read returns its word in the same cycle in which the access is registered, through the array read path, with no output pipeline stage. A write presents its data one taken cycle after its address. A one-entry pending-write register holds that word until the array takes it. Any read of the pending address in the meantime gets the pending bytes merged with the array word.

A loaded address starts a burst of up to four beats. The two low address bits come from a small counter that steps in wrapping linear order or in interleaved order (start XOR beat). A clock-qualify input freezes the whole block for a cycle. Three chip selects, per-lane write strobes and an asynchronous output enable complete the interface. The external pad combines `dIn`, `qOut` and the drive enable `qOe` into one bidirectional bus.

Top module: `zt_burst_sram`

## Requirements
- R1: Reset clears the control state. While reset is held and in the first cycle after it, with no access loaded, `qOe` is 0.
- R2: A read loaded on an edge (runEn=1, burstNext=0, all selects active, wrEn=0) drives the word at that address on `qOut` in the cycle that follows that edge. `qOe` is 1 in that cycle when `outEnN` is 0.
- R3: A write loaded on edge N takes its data word from `dIn` on the next taken edge. A later read of that address returns the word.
- R4: `laneMaskN` is active low and is sampled with the write data. Bit i clear writes bits 8i+7..8i. Every pattern from no lane (4'b1111) to all lanes (4'b0000) updates exactly the lanes selected.
- R5: A read loaded on the edge that captures a write's data, at that write's address, returns the written lanes from the new data and the other lanes from the old word.
- R6: Writes and reads alternate on consecutive edges with no inserted cycle, and every read returns the current data.
- R7: While runEn=0 the edge is ignored. `qOut` and `qOe` keep their values, no address or operation is loaded, and no write data is sampled. A write's data is instead taken on the next edge with runEn=1.
- R8: With burstNext=1 the burst advances. With orderIlv=0 at load, the low two address bits run start, start+1, start+2, start+3 modulo 4.
- R9: With orderIlv=1 at load, the low bits run start XOR beat for beats 0..3. `orderIlv` is ignored on advancing edges.
- R10: An advancing edge repeats the loaded operation (read, write or deselect). It keeps the upper address bits and ignores `wrEn`, `addr` and the chip selects. A write burst stores one data word per beat.
- R11: An access is loaded only when selA=1, selB=1 and selCN=0. Any other combination loads a deselect cycle with `qOe` 0 and no write.
- R12: `qOe` is 0 in the data cycle of every write. `outEnN`=1 forces `qOe` to 0 at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| runEn | input | 1 | 1 takes the edge, 0 ignores it |
| selA | input | 1 | Chip select, active high |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| wrEn | input | 1 | 1 loads a write, 0 a read |
| burstNext | input | 1 | 0 loads `addr`, 1 advances the burst |
| orderIlv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| laneMaskN | input | DATA_W/8 | Active-low byte-lane write strobes, sampled with data |
| dIn | input | DATA_W | Write data, sampled one taken edge after its address |
| outEnN | input | 1 | Asynchronous output enable, active low |
| qOut | output | DATA_W | Read data, valid in a read cycle |
| qOe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with ADDR_W=4 and the default 32-bit word. The sixteen-word array can then be filled and read back completely. All sixteen lane-strobe patterns, every burst start in both orders and all eight chip-select combinations can be swept exhaustively. The bench keeps a lane-wise arithmetic model of the array and uses it to predict every read, including the reads forwarded from the pending register.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // edge loads external address
    logic advance;     // edge steps the burst counter
    logic pendLoad;    // edge captures write data into pending register
    logic pendCommit;  // edge moves pending register into array
    logic pendLive;    // pending register holds an uncommitted write
    logic readCyc;     // current cycle is a read access
  } strobe_t;

endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    runEn,
  input  logic    selA,
  input  logic    selB,
  input  logic    selCN,
  input  logic    wrEn,
  input  logic    burstNext,
  output strobe_t strb
);

  logic selNow;
  op_e  opCur;
  op_e  opNext;
  logic pendValid;

  always_comb begin
    selNow = selA & selB & ~selCN;
    if (burstNext)    opNext = opCur;
    else if (!selNow) opNext = OP_IDLE;
    else if (wrEn)    opNext = OP_WRITE;
    else              opNext = OP_READ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opCur     <= OP_IDLE;
      pendValid <= 1'b0;
    end else if (runEn) begin
      opCur     <= opNext;
      pendValid <= (opCur == OP_WRITE);
    end
  end

  always_comb begin
    strb.load       = runEn & ~burstNext;
    strb.advance    = runEn & burstNext;
    strb.pendLoad   = runEn & (opCur == OP_WRITE);
    strb.pendCommit = runEn & pendValid;
    strb.pendLive   = pendValid;
    strb.readCyc    = (opCur == OP_READ);
  end

  // R3
  pend_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pendLoad |=> strb.pendLive);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> ($stable(opCur) && $stable(pendValid)));

endmodule

// File: rtl/zt_sram_dp.sv
module zt_sram_dp
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  orderIlv,
  input  logic [DATA_W-1:0]     dIn,
  input  logic [DATA_W/8-1:0]   laneMaskN,
  output logic [DATA_W-1:0]     rdData
);

  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 2;

  logic [HI_W-1:0]   baseHi;
  logic [1:0]        startLo;
  logic [1:0]        beat;
  logic              orderReg;
  logic [1:0]        curLo;
  logic [ADDR_W-1:0] curAddr;

  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic [LANES-1:0]  pendKeep;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] arrWord;
  logic              pendHit;

  // burst address sequencing
  always_comb begin
    curLo   = orderReg ? (startLo ^ beat) : (startLo + beat);
    curAddr = {baseHi, curLo};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi   <= '0;
      startLo  <= '0;
      beat     <= '0;
      orderReg <= 1'b0;
    end else if (strb.load) begin
      baseHi   <= addr[ADDR_W-1:2];
      startLo  <= addr[1:0];
      beat     <= '0;
      orderReg <= orderIlv;
    end else if (strb.advance) begin
      beat     <= beat + 2'd1;
    end
  end

  // pending write register
  always_ff @(posedge clk) begin
    if (strb.pendLoad) begin
      pendAddr <= curAddr;
      pendData <= dIn;
      pendKeep <= ~laneMaskN;
    end
  end

  // array update from the pending register
  always_ff @(posedge clk) begin
    if (strb.pendCommit) begin
      for (int l = 0; l < LANES; l++) begin
        if (pendKeep[l]) mem[pendAddr][8*l +: 8] <= pendData[8*l +: 8];
      end
    end
  end

  // flow-through read with lane-wise forwarding
  assign arrWord = mem[curAddr];
  assign pendHit = strb.pendLive && (pendAddr == curAddr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdData[8*g +: 8] = !strb.readCyc ? 8'h00 :
                              (pendHit && pendKeep[g]) ? pendData[8*g +: 8] :
                              arrWord[8*g +: 8];
  end

  // R8
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !orderReg) |=> (curLo == $past(curLo) + 2'd1));

  // R9
  ilv_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && orderReg) |=> ((curLo ^ startLo) == (($past(curLo) ^ startLo) + 2'd1)));

  // R10
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> $stable(baseHi));

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  runEn,
  input  logic                  selA,
  input  logic                  selB,
  input  logic                  selCN,
  input  logic                  wrEn,
  input  logic                  burstNext,
  input  logic                  orderIlv,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W/8-1:0]   laneMaskN,
  input  logic [DATA_W-1:0]     dIn,
  input  logic                  outEnN,
  output logic [DATA_W-1:0]     qOut,
  output logic                  qOe
);

  strobe_t strb;

  zt_sram_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .selA      (selA),
    .selB      (selB),
    .selCN     (selCN),
    .wrEn      (wrEn),
    .burstNext (burstNext),
    .strb      (strb)
  );

  zt_sram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (addr),
    .orderIlv  (orderIlv),
    .dIn       (dIn),
    .laneMaskN (laneMaskN),
    .rdData    (qOut)
  );

  assign qOe = strb.readCyc & ~outEnN;

  // R11
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !burstNext && !(selA && selB && !selCN)) |=> !qOe);

  // R12
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !burstNext && selA && selB && !selCN && wrEn) |=> !qOe);

  // R7
  stall_q_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> $stable(qOut));

endmodule

// File: tb/tb_zt_burst_sram.sv
module tb_zt_burst_sram;

  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN, runEn, selA, selB, selCN, wrEn, burstNext, orderIlv, outEnN;
  logic [AW-1:0] addr;
  logic [3:0]    laneMaskN;
  logic [DW-1:0] dIn;
  logic [DW-1:0] qOut;
  logic          qOe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [DW-1:0] mdl [16];

  always #5 clk = ~clk;

  zt_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .selA(selA), .selB(selB),
    .selCN(selCN), .wrEn(wrEn), .burstNext(burstNext), .orderIlv(orderIlv),
    .addr(addr), .laneMaskN(laneMaskN), .dIn(dIn), .outEnN(outEnN),
    .qOut(qOut), .qOe(qOe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setIdle();
    runEn = 1'b1; burstNext = 1'b0; selA = 1'b0; selB = 1'b1; selCN = 1'b0; wrEn = 1'b0;
  endtask

  task automatic ldRead(input logic [AW-1:0] a);
    runEn = 1'b1; burstNext = 1'b0; selA = 1'b1; selB = 1'b1; selCN = 1'b0; wrEn = 1'b0; addr = a;
  endtask

  task automatic ldWrite(input logic [AW-1:0] a);
    runEn = 1'b1; burstNext = 1'b0; selA = 1'b1; selB = 1'b1; selCN = 1'b0; wrEn = 1'b1; addr = a;
  endtask

  task automatic feed(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] m);
    dIn = d; laneMaskN = m;
    for (int l = 0; l < 4; l++) if (!m[l]) mdl[a][8*l +: 8] = d[8*l +: 8];
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'h3C00_0000 + 32'(a) * 32'h0001_0203 ^ (32'(a) << 20);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; outEnN = 1'b0; orderIlv = 1'b0; addr = '0; dIn = '0; laneMaskN = '0;
    setIdle();
    tick(); tick();
    chk(qOe == 1'b0, "R1 reset", 32'(qOe), 32'd0);
    rstN = 1'b1;
    tick();
    chk(qOe == 1'b0, "R1 after reset", 32'(qOe), 32'd0);

    // back-to-back fill of the whole array
    for (int a = 0; a < 16; a++) begin
      ldWrite(4'(a));
      if (a > 0) feed(4'(a - 1), pat(a - 1), 4'b0000);
      tick();
      chk(qOe == 1'b0, "R12 write data cycle", 32'(qOe), 32'd0);
    end
    feed(4'd15, pat(15), 4'b0000);
    setIdle();
    tick(); tick();

    // read sweep
    for (int a = 0; a < 16; a++) begin
      ldRead(4'(a));
      tick();
      chk(qOe == 1'b1, "R2 drive", 32'(qOe), 32'd1);
      chk(qOut == mdl[a], "R3 readback", qOut, mdl[a]);
    end

    // every lane pattern, read after commit
    for (int m = 0; m < 16; m++) begin
      ldWrite(4'd5);
      tick();
      feed(4'd5, ~(32'(m) * 32'h1111_1111) ^ 32'h0F0F_5A5A, 4'(m));
      setIdle();
      tick(); tick();
      ldRead(4'd5);
      tick();
      chk(qOut == mdl[5], "R4 lanes", qOut, mdl[5]);
    end

    // forwarding: read loaded on the write data edge
    for (int m = 0; m < 16; m++) begin
      ldWrite(4'd9);
      tick();
      feed(4'd9, 32'(m) * 32'h0102_0408 + 32'h7700_0011, 4'(m));
      ldRead(4'd9);
      tick();
      chk(qOut == mdl[9], "R5 forward", qOut, mdl[9]);
    end
    setIdle(); tick();

    // alternating write and read every edge
    for (int i = 0; i < 16; i++) begin
      ldWrite(4'(i));
      tick();
      feed(4'(i), pat(i) ^ 32'hA5A5_0000, 4'b0000);
      ldRead(4'((i + 7) % 16));
      tick();
      chk(qOut == mdl[(i + 7) % 16], "R6 alternate", qOut, mdl[(i + 7) % 16]);
    end
    setIdle(); tick();

    // stall
    ldRead(4'd2);
    tick();
    runEn = 1'b0; addr = 4'd6; wrEn = 1'b1;
    tick();
    chk(qOe == 1'b1 && qOut == mdl[2], "R7 hold read", qOut, mdl[2]);
    ldWrite(4'd4);
    tick();
    dIn = 32'hDEAD_0001; laneMaskN = 4'b0000;
    runEn = 1'b0;
    tick();
    chk(qOe == 1'b0, "R7 stalled data cycle", 32'(qOe), 32'd0);
    feed(4'd4, 32'hBEEF_0002, 4'b0000);
    setIdle();
    tick(); tick();
    ldRead(4'd4);
    tick();
    chk(qOut == mdl[4], "R7 data on next taken edge", qOut, mdl[4]);

    // burst reads, both orders, all starts
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        orderIlv = o[0];
        ldRead({2'b10, 2'(s)});
        tick();
        for (int b = 0; b < 4; b++) begin
          logic [1:0] lo;
          lo = (o == 1) ? (2'(s) ^ 2'(b)) : (2'(s) + 2'(b));
          chk(qOut == mdl[{2'b10, lo}], (o == 1) ? "R9 interleaved" : "R8 linear",
              qOut, mdl[{2'b10, lo}]);
          burstNext = 1'b1; selA = 1'b0; wrEn = 1'b1; orderIlv = ~o[0]; addr = 4'd0;
          tick();
        end
        setIdle(); tick();
      end
    end

    // burst write, interleaved from start 2, selects and wrEn ignored on advance
    orderIlv = 1'b1;
    ldWrite(4'b0110);
    tick();
    for (int b = 0; b < 4; b++) begin
      feed({2'b01, 2'd2 ^ 2'(b)}, 32'h5100_0000 + 32'(b) * 32'h0011_2233, 4'b0000);
      if (b < 3) begin
        burstNext = 1'b1; selA = 1'b0; wrEn = 1'b0; addr = 4'd15;
      end else begin
        setIdle();
      end
      tick();
    end
    setIdle(); tick();
    for (int lo = 0; lo < 4; lo++) begin
      ldRead({2'b01, 2'(lo)});
      tick();
      chk(qOut == mdl[{2'b01, 2'(lo)}], "R10 burst write", qOut, mdl[{2'b01, 2'(lo)}]);
    end

    // chip-select decode
    for (int c = 0; c < 8; c++) begin
      runEn = 1'b1; burstNext = 1'b0; wrEn = 1'b0; addr = 4'd1;
      selA = c[2]; selB = c[1]; selCN = c[0];
      tick();
      chk(qOe == (c == 6), "R11 select", 32'(qOe), 32'(c == 6));
    end
    runEn = 1'b1; burstNext = 1'b0; selA = 1'b0; selB = 1'b1; selCN = 1'b0; wrEn = 1'b1; addr = 4'd1;
    tick();
    dIn = 32'h0BAD_0BAD; laneMaskN = 4'b0000;
    setIdle();
    tick(); tick();
    ldRead(4'd1);
    tick();
    chk(qOut == mdl[1], "R11 deselected write ignored", qOut, mdl[1]);

    // asynchronous output enable
    ldRead(4'd3);
    tick();
    chk(qOe == 1'b1, "R12 enabled", 32'(qOe), 32'd1);
    outEnN = 1'b1;
    #1;
    chk(qOe == 1'b0, "R12 outEnN off", 32'(qOe), 32'd0);
    outEnN = 1'b0;
    #1;
    chk(qOe == 1'b1, "R12 outEnN on", 32'(qOe), 32'd1);
    setIdle(); tick();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule